// File: doc/BRIEF.md
# Dual Retriggerable One-Shot Pulse Generator

This block holds two independent, clock-driven monostable channels that share one clock. Each channel watches two trigger levels and one active-low clear input, all of them asynchronous to the clock. A valid trigger makes the channel drive a pulse on `q` whose length, in clock cycles, is read from that channel's `width` field at the moment the trigger is taken. The other output, `q_n`, is a separately registered complement of `q`.

A trigger is valid in two cases. The first is a rising transition on input `a` while input `b` is high. The second is a falling transition on `b` while `a` is low. Every other transition is ignored. A per-channel mode bit chooses between two behaviours when a trigger arrives during a pulse:
- With the bit set, the trigger restarts the count.
- With the bit clear, the trigger is dropped.

While the channel clear is held low, the channel's `q` output stays low and no trigger is taken.

Each channel passes its three inputs through a two-flop synchronizer. The channel then looks for transitions and registers the resulting trigger, so there is a fixed latency from an input change to the start of the pulse. The global reset is synchronous and active-high.

Top module: `dual_oneshot`

## Requirements
- R1: A rising `a` while `b` is high triggers a pulse. `q` goes high on the fourth rising clock edge after the input change and stays high for exactly `width` cycles.
- R2: A falling `b` while `a` is low triggers a pulse with the same latency and length as in R1.
- R3: No pulse results from any of these transitions:
  - a rising `a` while `b` is low;
  - a falling `b` while `a` is high;
  - any falling `a`;
  - any rising `b`.
- R4: While `clr_n` of a channel is low:
  - that channel's `q` is low from the third rising edge after the fall;
  - its `q_n` is high;
  - triggers are ignored.

  Releasing `clr_n` does not start a pulse, even with the trigger levels already in a valid state.
- R5: With `retrig` at 1, a valid trigger during a pulse restarts the full count. The pulse then ends `width` cycles after the point where a fresh trigger would have started. There is no low gap, even when the trigger lands on the last high cycle.
- R6: With `retrig` at 0, valid triggers during a pulse are ignored, and the pulse keeps its original length.
- R7: `width` (an unsigned count in cycles, channel k at bits `[k*CNT_W +: CNT_W]`) is sampled only when a trigger is accepted. Later changes do not alter a running pulse. A trigger with width 0 produces no pulse and leaves a running pulse untouched.
- R8: `q_n` is always the inverse of `q`, including during global reset.
- R9: Global reset drives every `q` low and every `q_n` high on the next edge. After reset is released, the settling synchronizers cause no pulse.
- R10: The channels are independent: triggers, clears and widths on one channel never change the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high global reset |
| in_a | input | N_CH | Trigger level `a` per channel (asynchronous) |
| in_b | input | N_CH | Trigger level `b` per channel (asynchronous) |
| clr_n | input | N_CH | Active-low channel clear (asynchronous) |
| retrig | input | N_CH | 1 = retriggerable, 0 = non-retriggerable, per channel |
| width | input | N_CH*CNT_W | Pulse length in cycles, one field per channel |
| q | output | N_CH | Pulse output per channel |
| q_n | output | N_CH | Complement of `q` per channel |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- **Retrigger on the final high cycle.** A counter that reloads one cycle late would show a one-cycle dip here. The scoreboard would then record two short pulses instead of one merged pulse.
- **Trigger ignored in non-retriggerable mode.** A design that wrongly accepts it would produce a pulse longer than expected.
- **Width changed mid-pulse, or set to zero.** A design that reads `width` continuously would truncate or stretch the pulse.
- **Clear released while `a` and `b` already sit at a triggering level.** An edge detector that does not track its inputs during clear would fire a spurious pulse here.
- **Rising `a` and falling `b` that are gated off by the level of the other input.** A design that treats any transition as a trigger would produce pulses the scoreboard never expected.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Synchronized input levels of one channel.
  typedef struct packed {
    logic clr_n;
    logic b;
    logic a;
  } os_lvl_t;

  localparam int LVL_W = $bits(os_lvl_t);

endpackage

// File: rtl/os_sync.sv
module os_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/os_trig_gate.sv
module os_trig_gate
  import oneshot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  os_lvl_t lvl,
  output logic    trig,
  output logic    clr_live
);

  // After reset, hold off edge detection until the synchronizer
  // and the delayed copies carry real input values.
  localparam int ARM_W = SYNC_STAGES + 1;

  logic [ARM_W-1:0] arm;
  logic             a_d, b_d;
  logic             a_up, b_dn, hit;

  assign clr_live = lvl.clr_n;
  assign a_up     = lvl.a & ~a_d;
  assign b_dn     = ~lvl.b & b_d;
  assign hit      = arm[ARM_W-1] & lvl.clr_n &
                    ((a_up & lvl.b) | (b_dn & ~lvl.a));

  always_ff @(posedge clk) begin
    if (rst) begin
      arm  <= '0;
      a_d  <= 1'b0;
      b_d  <= 1'b0;
      trig <= 1'b0;
    end else begin
      arm  <= {arm[ARM_W-2:0], 1'b1};
      a_d  <= lvl.a;
      b_d  <= lvl.b;
      trig <= hit;
    end
  end

endmodule

// File: rtl/os_timer.sv
module os_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_live,
  input  logic             trig,
  input  logic             retrig,
  input  logic [CNT_W-1:0] width,
  output logic             q,
  output logic             q_n
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic             take;

  always_comb begin
    take = trig && (width != '0) && (retrig || (cnt == '0));
    if (!clr_live)       cnt_nx = '0;
    else if (take)       cnt_nx = width;
    else if (cnt != '0)  cnt_nx = cnt - ONE;
    else                 cnt_nx = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      q   <= 1'b0;
      q_n <= 1'b1;
    end else begin
      cnt <= cnt_nx;
      q   <= (cnt_nx != '0);
      q_n <= (cnt_nx == '0);
    end
  end

endmodule

// File: rtl/os_channel.sv
module os_channel
  import oneshot_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             a,
  input  logic             b,
  input  logic             clr_n,
  input  logic             retrig,
  input  logic [CNT_W-1:0] width,
  output logic             trig,
  output logic             clr_live,
  output logic             q,
  output logic             q_n
);

  os_lvl_t raw, lvl;

  assign raw = '{clr_n: clr_n, b: b, a: a};

  os_sync #(
    .W      (LVL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (lvl)
  );

  os_trig_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .lvl      (lvl),
    .trig     (trig),
    .clr_live (clr_live)
  );

  os_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clr_live (clr_live),
    .trig     (trig),
    .retrig   (retrig),
    .width    (width),
    .q        (q),
    .q_n      (q_n)
  );

endmodule

// File: rtl/dual_oneshot.sv
module dual_oneshot #(
  parameter int N_CH        = 2,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_CH-1:0]       in_a,
  input  logic [N_CH-1:0]       in_b,
  input  logic [N_CH-1:0]       clr_n,
  input  logic [N_CH-1:0]       retrig,
  input  logic [N_CH*CNT_W-1:0] width,
  output logic [N_CH-1:0]       q,
  output logic [N_CH-1:0]       q_n
);

  logic [N_CH-1:0] trig_pulse;
  logic [N_CH-1:0] clr_sync;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    os_channel #(
      .CNT_W      (CNT_W),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .a        (in_a[k]),
      .b        (in_b[k]),
      .clr_n    (clr_n[k]),
      .retrig   (retrig[k]),
      .width    (width[k*CNT_W +: CNT_W]),
      .trig     (trig_pulse[k]),
      .clr_live (clr_sync[k]),
      .q        (q[k]),
      .q_n      (q_n[k])
    );
  end

endmodule

// File: rtl/os_checker.sv
module os_checker #(
  parameter int N_CH  = 2,
  parameter int CNT_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_CH*CNT_W-1:0] width,
  input logic [N_CH-1:0]       trig_pulse,
  input logic [N_CH-1:0]       clr_sync,
  input logic [N_CH-1:0]       q,
  input logic [N_CH-1:0]       q_n
);

  for (genvar i = 0; i < N_CH; i++) begin : g_chk
    p_qn_inverse_r8: assert property (@(posedge clk) disable iff (rst)
      q_n[i] == ~q[i]);

    p_reset_idle_r9: assert property (@(posedge clk)
      rst |=> (!q[i] && q_n[i]));

    p_start_from_trigger_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(q[i]) |-> $past(trig_pulse[i]));

    p_clear_holds_low_r4: assert property (@(posedge clk) disable iff (rst)
      !clr_sync[i] |=> !q[i]);

    p_zero_width_idle_r7: assert property (@(posedge clk) disable iff (rst)
      (trig_pulse[i] && clr_sync[i] && (width[i*CNT_W +: CNT_W] == '0) && !q[i])
      |=> !q[i]);
  end

endmodule

bind dual_oneshot os_checker #(.N_CH(N_CH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .width      (width),
  .trig_pulse (trig_pulse),
  .clr_sync   (clr_sync),
  .q          (q),
  .q_n        (q_n)
);

// File: tb/dual_oneshot_test.sv
module dual_oneshot_test;

  localparam int N_CH  = 2;
  localparam int CNT_W = 8;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [N_CH-1:0]       in_a = '0;
  logic [N_CH-1:0]       in_b = '1;
  logic [N_CH-1:0]       clr_n = '1;
  logic [N_CH-1:0]       retrig = '0;
  logic [N_CH*CNT_W-1:0] width = '0;
  logic [N_CH-1:0]       q, q_n;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int    start;
    int    len;
    string req;
  } exp_t;

  exp_t sbq [N_CH][$];
  int   rise_at [N_CH];
  logic q_prev [N_CH];

  dual_oneshot #(.N_CH(N_CH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .in_a(in_a), .in_b(in_b), .clr_n(clr_n),
    .retrig(retrig), .width(width), .q(q), .q_n(q_n)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulse(input int ch, input int start, input int len, input string req);
    exp_t e;
    e.start = start; e.len = len; e.req = req;
    sbq[ch].push_back(e);
  endtask

  task automatic set_w(input int ch, input int w);
    width[ch*CNT_W +: CNT_W] = CNT_W'(w);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: complement check every cycle, pulse measurement against the scoreboard.
  always @(negedge clk) begin
    if (rst) begin
      for (int ch = 0; ch < N_CH; ch++) q_prev[ch] = 1'b0;
    end else begin
      for (int ch = 0; ch < N_CH; ch++) begin
        check(q_n[ch] === ~q[ch], "R8 complement", int'(q_n[ch]), int'(~q[ch]));
        if (q[ch] && !q_prev[ch]) rise_at[ch] = cyc;
        if (!q[ch] && q_prev[ch]) begin
          checks++;
          if (sbq[ch].size() == 0) begin
            fails++;
            $display("FAIL R3/R6 ch%0d: unexpected pulse start %0d len %0d, expected none",
                     ch, rise_at[ch], cyc - rise_at[ch]);
          end else begin
            exp_t e;
            e = sbq[ch].pop_front();
            if (rise_at[ch] != e.start || (cyc - rise_at[ch]) != e.len) begin
              fails++;
              $display("FAIL %s ch%0d: pulse start %0d len %0d, expected start %0d len %0d",
                       e.req, ch, rise_at[ch], cyc - rise_at[ch], e.start, e.len);
            end
          end
        end
        q_prev[ch] = q[ch];
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    wait_n(5);
    // R8, R9: state during global reset
    check(q == '0, "R9 reset q", int'(q), 0);
    check(q_n == '1, "R8 reset q_n", int'(q_n), 3);
    rst = 1'b0;
    wait_n(10);
    check(q == '0, "R9 no pulse after release", int'(q), 0);
    check(q_n == '1, "R9 q_n after release", int'(q_n), 3);

    // R1: rising a with b high, ch0 non-retriggerable
    set_w(0, 6); in_a[0] = 1'b1; c = cyc;
    expect_pulse(0, c + 4, 6, "R1");
    wait_n(3); in_a[0] = 1'b0;
    wait_n(15);

    // R2: falling b with a low, ch1
    set_w(1, 9); in_b[1] = 1'b0; c = cyc;
    expect_pulse(1, c + 4, 9, "R2");
    wait_n(3); in_b[1] = 1'b1;
    wait_n(20);

    // R3: non-triggering transitions on ch0 (width nonzero)
    set_w(0, 5);
    in_a[0] = 1'b1; in_b[0] = 1'b0; wait_n(5);   // a up with b low, b down with a high
    in_a[0] = 1'b0; wait_n(5);                   // a falls
    in_a[0] = 1'b1; wait_n(5);                   // a rises, b low
    in_b[0] = 1'b1; wait_n(5);                   // b rises
    in_b[0] = 1'b0; wait_n(5);                   // b falls, a high
    in_a[0] = 1'b0; in_b[0] = 1'b1; wait_n(10);  // a falls, b rises
    check(q[0] == 1'b0, "R3 no pulse", int'(q[0]), 0);
    check(sbq[0].size() == 0, "R3 scoreboard", sbq[0].size(), 0);

    // R7: width 0 gives no pulse
    set_w(0, 0); in_a[0] = 1'b1; wait_n(3); in_a[0] = 1'b0; wait_n(10);
    check(q[0] == 1'b0, "R7 zero width", int'(q[0]), 0);

    // R6 + R7: non-retriggerable ignores trigger; width change mid-pulse ignored
    set_w(0, 12); in_a[0] = 1'b1; c = cyc;
    expect_pulse(0, c + 4, 12, "R6");
    wait_n(3); in_a[0] = 1'b0;
    wait_n(3); set_w(0, 3); in_b[0] = 1'b0;
    wait_n(2); in_b[0] = 1'b1;
    wait_n(20);

    // R5: retrigger restarts full width, ch1
    retrig[1] = 1'b1;
    set_w(1, 10); in_b[1] = 1'b0; c = cyc;
    expect_pulse(1, c + 4, 13, "R5 restart");
    wait_n(3); in_b[1] = 1'b1;
    wait_n(3); set_w(1, 7); in_a[1] = 1'b1;       // at c+6, ends c+17
    wait_n(3); in_a[1] = 1'b0;
    wait_n(25);

    // R5: retrigger landing on the last high cycle, no gap
    set_w(1, 5); in_a[1] = 1'b1; c = cyc;
    expect_pulse(1, c + 4, 9, "R5 last cycle");
    wait_n(3); in_a[1] = 1'b0;
    wait_n(2); set_w(1, 4); in_b[1] = 1'b0;       // at c+5
    wait_n(3); in_b[1] = 1'b1;
    wait_n(20);

    // R7: zero-width retrigger leaves a running pulse alone
    set_w(1, 8); in_a[1] = 1'b1; c = cyc;
    expect_pulse(1, c + 4, 8, "R7 zero retrigger");
    wait_n(3); in_a[1] = 1'b0;
    wait_n(2); set_w(1, 0); in_b[1] = 1'b0;
    wait_n(3); in_b[1] = 1'b1;
    wait_n(20);

    // R4: clear cuts a pulse, blocks triggers, release does not trigger
    set_w(0, 20); in_a[0] = 1'b1; c = cyc;
    expect_pulse(0, c + 4, 8, "R4 cut");
    wait_n(3); in_a[0] = 1'b0;
    wait_n(6); clr_n[0] = 1'b0;                   // at c+9, low seen at c+12
    wait_n(4); in_b[0] = 1'b0;
    wait_n(4); in_b[0] = 1'b1;
    wait_n(4); in_a[0] = 1'b1;
    wait_n(4);
    check(q[0] == 1'b0, "R4 held low", int'(q[0]), 0);
    check(q_n[0] == 1'b1, "R4 q_n high", int'(q_n[0]), 1);
    clr_n[0] = 1'b1;
    wait_n(20);
    check(q[0] == 1'b0, "R4 release no pulse", int'(q[0]), 0);
    in_a[0] = 1'b0; wait_n(5);
    set_w(0, 3); in_a[0] = 1'b1; c = cyc;
    expect_pulse(0, c + 4, 3, "R4 after release");
    wait_n(3); in_a[0] = 1'b0;
    wait_n(15);

    // R10: channels independent, clearing ch1 leaves ch0 running
    set_w(0, 15); in_a[0] = 1'b1; c = cyc;
    expect_pulse(0, c + 4, 15, "R10 ch0");
    wait_n(2); set_w(1, 6); in_b[1] = 1'b0;
    expect_pulse(1, c + 6, 6, "R10 ch1");
    wait_n(1); in_a[0] = 1'b0;
    wait_n(2); in_b[1] = 1'b1;
    wait_n(9); clr_n[1] = 1'b0;                   // at c+14
    wait_n(3); clr_n[1] = 1'b1;
    wait_n(25);

    check(sbq[0].size() == 0, "R10 ch0 all pulses seen", sbq[0].size(), 0);
    check(sbq[1].size() == 0, "R10 ch1 all pulses seen", sbq[1].size(), 0);

    done = 1;
    summary();
    $finish;
  end

endmodule